// File: doc/BRIEF.md
# Prescaled Periodic Tick Timer with Watchdog

This block derives a periodic system tick from a slow reference clock and supervises software with an 8-bit watchdog. The reference clock, here `clk_i`, feeds a free-running prescaler. The prescaler produces a clock-enable strobe once every 2^k cycles, where k is a programmable divide exponent. Each strobe moves a 16-bit auto-reloading down-counter one step. When that counter sits at zero, the block raises a single-cycle tick and reloads the counter on the following strobe.

Software programs the block through a small write-only register port. The port carries four things:
- the divide exponent;
- the reload value, which takes effect only at the next wrap;
- a restart bit, which clears itself once the counter has been reloaded on the next strobe;
- the watchdog controls: preset, service, enable, clock source and lock.

The watchdog counts either prescaler strobes or ticks. It raises a sticky expiry flag once it runs down to zero. Two lock bits freeze the timer section and the watchdog section independently, and only reset releases them.

Top module: `tick_wdog_top`

## Requirements
- R1: Register 0 bits [2:0] set the divide exponent. `stb_o` pulses once every 2^exponent clocks, and on every clock when the exponent is 0. The values 6 and 7 act as 5.
- R2: The timer count steps down by one on each strobe, starting from the reload value.
- R3: A strobe seen while the count is zero reloads the count. The tick period is therefore (reload + 1) strobes, and a reload of 0 gives a tick on every strobe.
- R4: `tick_o` is high for exactly one clock: the strobe clock in which the count is zero.
- R5: A write to register 1 (16-bit reload) leaves the running count alone. The new value is used from the next wrap onward.
- R6: Writing 1 to register 2 bit 0 reloads the count on the next strobe, and the request then clears itself. No tick is issued while the request is pending, so the first tick comes (reload + 1) strobes after the write.
- R7: Setting register 0 bit 3 locks the timer section. While locked, writes to registers 0 and 1 are ignored until reset, but a restart is still honoured.
- R8: Register 3 holds the watchdog fields: preset in [7:0], service in bit 8, enable in bit 10, and clock source in bit 11 (0 selects strobes, 1 selects ticks). An accepted write to register 3, or a service, loads the counter with the preset. When enabled, the counter decrements on each selected event, and `wd_expired_o` rises one clock after the counter reaches zero.
- R9: `wd_expired_o` stays high until reset; a service does not clear it.
- R10: Register 3 bit 12 locks the watchdog section. After that, the preset, enable and clock source ignore writes until reset. A service still reloads the counter with the held preset.
- R11: After reset the divide exponent is 0, the reload value and the count are 0xFFFF, both locks are clear, the watchdog is disabled with preset 0xFF, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 16 | Write data |
| stb_o | output | 1 | Prescaled clock-enable strobe |
| tick_o | output | 1 | Periodic tick, one clock wide |
| wd_expired_o | output | 1 | Sticky watchdog expiry |

## Verification
A wrong prescaler phase or mask shows up as a wrong tick spacing within one tick period. A corrupted timer count, a lost restart request or a reload applied too early moves the next tick, visible at `tick_o` within reload + 1 strobes. A watchdog counter that loads or decrements wrongly shifts the rise of `wd_expired_o` away from preset + 1 events after the last load. A lock that leaks lets a later write change the tick period or the expiry time, which is visible on the next period.

// File: rtl/tick_wdog_pkg.sv
package tick_wdog_pkg;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned DATA_W  = 16;

  localparam logic [ADDR_W-1:0] A_CFG     = 2'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD  = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL    = 2'd2;
  localparam logic [ADDR_W-1:0] A_WDOG    = 2'd3;

  localparam int unsigned B_TMR_LOCK  = 3;
  localparam int unsigned B_RESTART   = 0;
  localparam int unsigned B_WD_SERV   = 8;
  localparam int unsigned B_WD_EN     = 10;
  localparam int unsigned B_WD_SEL    = 11;
  localparam int unsigned B_WD_LOCK   = 12;
endpackage

// File: rtl/tw_prescale.sv
module tw_prescale #(
  parameter int unsigned MDIV_W   = 3,
  parameter int unsigned MDIV_MAX = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MDIV_W-1:0] mdiv_i,
  output logic              stb_o
);
  localparam int unsigned CNT_W = (MDIV_MAX > 0) ? MDIV_MAX : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) mask[i] = (32'(i) < 32'(mdiv_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign stb_o = ((cnt_q & mask) == mask);

  // strobes never come back-to-back when dividing
  p_stb_spacing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_o && mdiv_i != '0 && $stable(mdiv_i)) |=> !stb_o);
endmodule

// File: rtl/tw_timer.sv
module tw_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic [W-1:0] reload_i,
  input  logic         restart_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      pend_q <= 1'b0;
    end else begin
      if (stb_i) begin
        if (pend_q || cnt_q == '0) cnt_q <= reload_i;
        else                       cnt_q <= cnt_q - 1'b1;
        pend_q <= 1'b0;
      end
      if (restart_i) pend_q <= 1'b1;
    end
  end

  assign tick_o = stb_i && (cnt_q == '0) && !pend_q;

  p_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !pend_q && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == $past(reload_i));

  p_restart_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && stb_i && !restart_i) |=> (!pend_q && cnt_q == $past(reload_i)));

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(cnt_q));
endmodule

// File: rtl/tw_wdog.sv
module tw_wdog #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_i,
  input  logic         tick_i,
  input  logic         sel_i,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] preset_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;
  logic         ev;

  assign ev = sel_i ? tick_i : stb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '1;
      expired_o <= 1'b0;
    end else begin
      if (load_i)                              cnt_q <= preset_i;
      else if (en_i && ev && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
      if (en_i && !load_i && cnt_q == '0)      expired_o <= 1'b1;
    end
  end

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |=> expired_o);

  p_no_event_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(en_i && ev)) |=> $stable(cnt_q));

  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(preset_i));
endmodule

// File: rtl/tick_wdog_top.sv
module tick_wdog_top
  import tick_wdog_pkg::*;
#(
  parameter int unsigned MDIV_W   = 3,
  parameter int unsigned MDIV_MAX = 5,
  parameter int unsigned TMR_W    = 16,
  parameter int unsigned WD_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              stb_o,
  output logic              tick_o,
  output logic              wd_expired_o
);
  logic [MDIV_W-1:0] mdiv_q, mdiv_wr;
  logic [TMR_W-1:0]  reload_q;
  logic              tmr_lock_q;
  logic [WD_W-1:0]   wd_preset_q, wd_load_val;
  logic              wd_en_q, wd_sel_q, wd_lock_q;
  logic              wr_cfg, wr_rld, wr_ctrl, wr_wd;
  logic              restart, wd_load;

  assign wr_cfg  = wr_en_i && wr_addr_i == A_CFG    && !tmr_lock_q;
  assign wr_rld  = wr_en_i && wr_addr_i == A_RELOAD && !tmr_lock_q;
  assign wr_ctrl = wr_en_i && wr_addr_i == A_CTRL;
  assign wr_wd   = wr_en_i && wr_addr_i == A_WDOG;

  assign mdiv_wr = (32'(wr_data_i[MDIV_W-1:0]) > MDIV_MAX) ? MDIV_W'(MDIV_MAX)
                                                           : wr_data_i[MDIV_W-1:0];
  assign restart = wr_ctrl && wr_data_i[B_RESTART];
  // unlocked config write or any service reloads the watchdog
  assign wd_load     = wr_wd && (!wd_lock_q || wr_data_i[B_WD_SERV]);
  assign wd_load_val = wd_lock_q ? wd_preset_q : wr_data_i[WD_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdiv_q      <= '0;
      reload_q    <= '1;
      tmr_lock_q  <= 1'b0;
      wd_preset_q <= '1;
      wd_en_q     <= 1'b0;
      wd_sel_q    <= 1'b0;
      wd_lock_q   <= 1'b0;
    end else begin
      if (wr_cfg) begin
        mdiv_q     <= mdiv_wr;
        tmr_lock_q <= wr_data_i[B_TMR_LOCK];
      end
      if (wr_rld) reload_q <= wr_data_i[TMR_W-1:0];
      if (wr_wd && !wd_lock_q) begin
        wd_preset_q <= wr_data_i[WD_W-1:0];
        wd_en_q     <= wr_data_i[B_WD_EN];
        wd_sel_q    <= wr_data_i[B_WD_SEL];
        wd_lock_q   <= wr_data_i[B_WD_LOCK];
      end
    end
  end

  tw_prescale #(.MDIV_W(MDIV_W), .MDIV_MAX(MDIV_MAX)) u_presc (
    .clk_i (clk_i), .rst_ni (rst_ni), .mdiv_i (mdiv_q), .stb_o (stb_o)
  );

  tw_timer #(.W(TMR_W)) u_timer (
    .clk_i (clk_i), .rst_ni (rst_ni), .stb_i (stb_o),
    .reload_i (reload_q), .restart_i (restart), .tick_o (tick_o)
  );

  tw_wdog #(.W(WD_W)) u_wdog (
    .clk_i (clk_i), .rst_ni (rst_ni), .stb_i (stb_o), .tick_i (tick_o),
    .sel_i (wd_sel_q), .en_i (wd_en_q), .load_i (wd_load),
    .preset_i (wd_load_val), .expired_o (wd_expired_o)
  );

  p_tmr_lock_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_lock_q |=> (tmr_lock_q && $stable(reload_q) && $stable(mdiv_q)));

  p_wd_lock_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_lock_q |=> (wd_lock_q && $stable(wd_en_q) && $stable(wd_preset_q) && $stable(wd_sel_q)));

  p_mdiv_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(mdiv_q) <= MDIV_MAX);
endmodule

// File: tb/tick_wdog_top_tb.sv
`timescale 1ns/1ps
module tick_wdog_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        stb, tick, wd_exp;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  tick_wdog_top u_dut (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .wr_addr_i (wr_addr),
    .wr_data_i (wr_data), .stb_o (stb), .tick_o (tick), .wd_expired_o (wd_exp)
  );

  localparam int NV = 6;
  localparam int V_MDIV [NV] = '{0, 0, 1, 2, 5, 7};
  localparam int V_RLD  [NV] = '{3, 0, 4, 9, 2, 1};
  localparam int V_PER  [NV] = '{4, 1, 10, 40, 96, 64};

  localparam int WD_EN   = 1 << 10;
  localparam int WD_SEL  = 1 << 11;
  localparam int WD_LOCK = 1 << 12;
  localparam int WD_SERV = 1 << 8;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick();
    while (!tick) @(negedge clk);
  endtask

  task automatic period(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick);
  endtask

  task automatic until_exp(output int n);
    n = 0;
    while (!wd_exp) begin @(negedge clk); n++; end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(tick == 1'b0 && wd_exp == 1'b0, "R11 outputs low in reset", int'(tick | wd_exp), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(stb == 1'b1, "R1 strobe every clock at exponent 0", int'(stb), 1);
    // reset reload 0xFFFF: first tick after 65535 steps
    n = 1;
    while (!tick) begin @(negedge clk); n++; end
    check(n == 65535, "R11 first tick from reset reload", n, 65535);
    check(wd_exp == 1'b0, "R11 watchdog disabled after reset", int'(wd_exp), 0);
    @(negedge clk);
    check(tick == 1'b0, "R4 tick one clock wide", int'(tick), 0);

    // table: exponent, reload, expected period in clocks
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, V_MDIV[i]);
      wr(2'd1, V_RLD[i]);
      wr(2'd2, 1);
      wait_tick();
      period(n);
      check(n == V_PER[i], "R3 R1 tick period", n, V_PER[i]);
      if (V_MDIV[i] != 0) begin
        @(negedge clk);
        check(tick == 1'b0, "R4 tick single clock when dividing", int'(tick), 0);
      end
    end

    // R5: reload write deferred to next wrap
    wr(2'd0, 0);
    wr(2'd1, 9);
    wr(2'd2, 1);
    wait_tick();
    wr(2'd1, 2);
    n = 1;
    while (!tick) begin @(negedge clk); n++; end
    check(n == 10, "R5 running period keeps old reload", n, 10);
    period(n);
    check(n == 3, "R5 new reload after wrap", n, 3);

    // R6: restart mid-count
    wr(2'd1, 9);
    wait_tick();
    period(n);
    check(n == 10, "R2 period with reload 9", n, 10);
    repeat (3) @(negedge clk);
    wr(2'd2, 1);
    n = 0;
    while (!tick) begin @(negedge clk); n++; end
    check(n == 10, "R6 restart latency", n, 10);
    period(n);
    check(n == 10, "R6 restart clears itself", n, 10);

    // R7: timer lock
    wr(2'd0, 1 << 3);
    wr(2'd0, 3);
    wr(2'd1, 20);
    wr(2'd2, 1);
    wait_tick();
    period(n);
    check(n == 10, "R7 locked timer ignores writes", n, 10);
    do_reset();
    wr(2'd1, 4);
    wr(2'd2, 1);
    wait_tick();
    period(n);
    check(n == 5, "R7 reset releases timer lock", n, 5);

    // R8: service keeps watchdog alive, then expiry timing
    wr(2'd3, 5 | WD_EN);
    for (int k = 0; k < 10; k++) begin
      repeat (3) @(negedge clk);
      wr(2'd3, 5 | WD_EN | WD_SERV);
    end
    check(wd_exp == 1'b0, "R8 serviced watchdog stays quiet", int'(wd_exp), 0);
    until_exp(n);
    check(n == 6, "R8 expiry after preset+1 strobes", n, 6);
    wr(2'd3, 5 | WD_EN | WD_SERV);
    repeat (5) @(negedge clk);
    check(wd_exp == 1'b1, "R9 expiry sticky after service", int'(wd_exp), 1);

    // R8: tick-clocked watchdog
    do_reset();
    wr(2'd1, 3);
    wr(2'd2, 1);
    wr(2'd3, 2 | WD_EN | WD_SEL);
    repeat (6) @(negedge clk);
    check(wd_exp == 1'b0, "R8 tick source slower than strobe", int'(wd_exp), 0);
    repeat (12) @(negedge clk);
    check(wd_exp == 1'b1, "R8 tick source expires", int'(wd_exp), 1);

    // R10: watchdog lock
    do_reset();
    wr(2'd3, 50 | WD_EN | WD_LOCK);
    wr(2'd3, 0);
    repeat (5) @(negedge clk);
    check(wd_exp == 1'b0, "R10 locked preset not reloaded", int'(wd_exp), 0);
    wr(2'd3, WD_SERV);
    until_exp(n);
    check(n == 51, "R10 service uses held preset, enable kept", n, 51);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule